// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block sequences bus cycles for a processor whose low 16 address bits and 16 data bits share one set of lines, with four more lines for address bits 19..16. A client presents a read or write request, selecting memory or I/O and marking which bytes take part. The block then runs a fixed sequence of bus states: T1, T2, T3, any number of wait states (TW), and T4.

In T1 the block puts the address on the shared lines and pulses the address latch enable so that an external latch can hold it. After T1 the shared lines are released for a read or carry the write data. The upper four lines switch from address to a status nibble. The transceiver enable, the direction line and the read and write strobes are timed around that switch. A slow device holds the ready input low to stretch the cycle. Read data is returned with a one-cycle done pulse in T4, which is also the first state in which a new request can be accepted.

Top module: `mux_bus_seq`

## Requirements
- R1: Out of reset and while idle: ale=0, rd_n=1, wr_n=1, den_n=1, bhe_n=1, ad_oe=0, upper_out=0, busy=0, done=0.
- R2: A request with req_valid=1 is accepted on a clock edge in the idle state. The next cycle is T1, with ale=1, ad_oe=1, ad_out=addr[15:0] and upper_out=addr[19:16].
- R3: From T2 through T4, upper_out carries the status nibble {1'b0, 1'b0, write, mem}.
- R4: From T1 through T4, m_io equals the request's mem bit (1 = memory, 0 = I/O) and dt_r equals its write bit (1 = transmit, 0 = receive).
- R5: For a read, rd_n is low in T2, T3 and every TW, and ad_oe is low from T2 through T4. ad_in is captured on the edge that ends the last T3/TW and appears on rdata while done is high.
- R6: For a write, wr_n is low in T2, T3 and every TW, and ad_oe=1 with ad_out equal to the write data from T2 through T4.
- R7: den_n is low from T2 through T4 and high in T1.
- R8: ready is sampled only on the edge ending T3 or a TW. If it is low the next state is TW, and if it is high the next state is T4. Its value in T1 or T2 has no effect.
- R9: done is high for exactly the one T4 cycle. busy is high in T1, T2, T3 and TW, and low in idle and T4.
- R10: A request raised while busy is ignored: the running cycle keeps its address, data and controls, and no extra cycle follows.
- R11: A request that is valid in T4 is accepted, and the next cycle is T1 of the new transfer, with no idle cycle between.
- R12: be[1] marks the upper byte and be[0] the lower byte. bhe_n is low from T1 through T4 exactly when be[1]=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory, 0 = I/O |
| req_addr | input | 20 | Transfer address |
| req_be | input | 2 | Byte enables, bit 1 upper byte |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Cycle in progress, requests ignored |
| done | output | 1 | Transfer complete pulse (T4) |
| rdata | output | 16 | Read data |
| ready | input | 1 | Device ready, active high |
| ad_in | input | 16 | Shared lines, input side |
| ad_out | output | 16 | Shared lines, output side |
| ad_oe | output | 1 | Shared lines output enable |
| upper_out | output | 4 | Address 19..16 in T1, status afterwards |
| ale | output | 1 | Address latch enable |
| den_n | output | 1 | Transceiver enable, active low |
| dt_r | output | 1 | Transceiver direction |
| m_io | output | 1 | Memory/I-O select |
| bhe_n | output | 1 | Upper byte enable, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The bench varies the number of wait states and changes ad_in on every wait cycle. A design that sampled ready one state early, or captured read data from a wait cycle, would return stale data or leave T3 too soon. The bench drives ready high during T2 to catch a sequencer that reads it there. It also raises a conflicting request mid-cycle, which a design missing the busy guard would latch, corrupting the address or data. A request presented in T4 must start T1 at once, and a design that passed through idle would show a missing ale.

// File: rtl/mux_bus_seq.sv
module mux_bus_seq #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_mem,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_be,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  input  logic          ready,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [AW-DW-1:0] upper_out,
  output logic          ale,
  output logic          den_n,
  output logic          dt_r,
  output logic          m_io,
  output logic          bhe_n,
  output logic          rd_n,
  output logic          wr_n
);
  localparam int UW = AW - DW;

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_T3, S_TW, S_T4} st_t;
  st_t st;

  logic [AW-1:0] c_addr;
  logic [DW-1:0] c_wdata;
  logic          c_write, c_mem, c_hi;

  wire accept  = req_valid && (st == S_IDLE || st == S_T4);
  wire in_cyc  = (st != S_IDLE);
  wire strobe  = (st == S_T2 || st == S_T3 || st == S_TW);
  wire data_ph = strobe || (st == S_T4);
  wire sample  = (st == S_T3 || st == S_TW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      c_addr  <= '0;
      c_wdata <= '0;
      c_write <= 1'b0;
      c_mem   <= 1'b0;
      c_hi    <= 1'b0;
      rdata   <= '0;
    end else begin
      if (accept) begin
        st      <= S_T1;
        c_addr  <= req_addr;
        c_wdata <= req_wdata;
        c_write <= req_write;
        c_mem   <= req_mem;
        c_hi    <= req_be[1];
      end else begin
        case (st)
          S_T1:    st <= S_T2;
          S_T2:    st <= S_T3;
          S_T3,
          S_TW:    st <= ready ? S_T4 : S_TW;
          default: st <= S_IDLE;
        endcase
      end
      if (sample && ready && !c_write) rdata <= ad_in;
    end
  end

  assign busy      = in_cyc && (st != S_T4);
  assign done      = (st == S_T4);
  assign ale       = (st == S_T1);
  assign ad_oe     = ale || (data_ph && c_write);
  assign ad_out    = ale ? c_addr[DW-1:0] : c_wdata;
  assign upper_out = ale ? c_addr[AW-1:DW]
                   : (data_ph ? {{(UW-2){1'b0}}, c_write, c_mem} : '0);
  assign den_n     = !data_ph;
  assign dt_r      = c_write;
  assign m_io      = c_mem;
  assign bhe_n     = !(in_cyc && c_hi);
  assign rd_n      = !(strobe && !c_write);
  assign wr_n      = !(strobe && c_write);

  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale); // R2
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe); // R5
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n)); // R6
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !ready) |=> (st == S_TW)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(c_addr) && $stable(c_wdata)); // R10
  AST_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && req_valid) |=> ale); // R11
endmodule

// File: tb/sim_mux_bus_seq.sv
module sim_mux_bus_seq;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_mem = 0;
  logic [19:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0, ad_in = '0;
  logic ready = 0;
  logic busy, done, ad_oe, ale, den_n, dt_r, m_io, bhe_n, rd_n, wr_n;
  logic [15:0] rdata, ad_out;
  logic [3:0]  upper_out;
  int errs = 0, checks = 0;

  always #5 clk = ~clk;

  mux_bus_seq u0 (.clk, .rst_n, .req_valid, .req_write, .req_mem, .req_addr,
    .req_be, .req_wdata, .busy, .done, .rdata, .ready, .ad_in, .ad_out, .ad_oe,
    .upper_out, .ale, .den_n, .dt_r, .m_io, .bhe_n, .rd_n, .wr_n);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] stat_nib(input logic w, input logic m);
    return {2'b00, w, m};
  endfunction

  task automatic chk_idle();
    chk("R1 ale", ale, 0);      chk("R1 rd_n", rd_n, 1);
    chk("R1 wr_n", wr_n, 1);    chk("R1 den_n", den_n, 1);
    chk("R1 bhe_n", bhe_n, 1);  chk("R1 ad_oe", ad_oe, 0);
    chk("R1 upper", upper_out, 0);
    chk("R1 busy", busy, 0);    chk("R1 done", done, 0);
  endtask

  task automatic chk_data(input logic w, input logic m, input logic [1:0] be,
                          input logic [15:0] wd, input logic strb);
    chk("R3 status", upper_out, stat_nib(w, m));
    chk("R4 m_io", m_io, m);    chk("R4 dt_r", dt_r, w);
    chk("R7 den_n", den_n, 0);  chk("R12 bhe_n", bhe_n, !be[1]);
    chk("R2 ale low", ale, 0);
    if (w) begin
      chk("R6 ad_oe", ad_oe, 1); chk("R6 ad_out", ad_out, wd);
      chk("R6 wr_n", wr_n, !strb); chk("R5 rd_n idle", rd_n, 1);
    end else begin
      chk("R5 ad_oe", ad_oe, 0);
      chk("R5 rd_n", rd_n, !strb); chk("R6 wr_n idle", wr_n, 1);
    end
  endtask

  // Entry: at a negedge where the design is idle or in T4.
  task automatic run(input logic w, input logic m, input logic [19:0] a,
                     input logic [1:0] be, input logic [15:0] wd,
                     input logic [15:0] rd, input int waits, input bit inject);
    req_valid = 1; req_write = w; req_mem = m; req_addr = a;
    req_be = be; req_wdata = wd; ready = 0; ad_in = 16'($urandom);
    @(negedge clk); // T1
    req_valid = 0;
    chk("R2 ale", ale, 1);          chk("R2 ad_oe", ad_oe, 1);
    chk("R2 ad_out", ad_out, a[15:0]); chk("R2 upper", upper_out, a[19:16]);
    chk("R7 den_n T1", den_n, 1);   chk("R12 bhe_n T1", bhe_n, !be[1]);
    chk("R4 m_io T1", m_io, m);     chk("R4 dt_r T1", dt_r, w);
    chk("R9 busy T1", busy, 1);     chk("R9 done T1", done, 0);
    @(negedge clk); // T2
    chk_data(w, m, be, wd, 1);
    chk("R9 busy T2", busy, 1);
    ready = 1; // R8: must not be sampled in T2
    if (inject) begin // R10
      req_valid = 1; req_write = !w; req_mem = !m; req_addr = ~a;
      req_wdata = ~wd; req_be = ~be;
    end
    @(negedge clk); // T3
    req_valid = 0;
    chk_data(w, m, be, wd, 1);
    chk("R8 in T3", busy, 1); chk("R9 done T3", done, 0);
    ready = (waits == 0);
    ad_in = (waits == 0) ? rd : 16'($urandom);
    for (int k = 1; k <= waits; k++) begin
      @(negedge clk); // TW
      chk_data(w, m, be, wd, 1);
      chk("R8 wait busy", busy, 1); chk("R8 wait done", done, 0);
      ready = (k == waits);
      ad_in = (k == waits) ? rd : 16'($urandom);
    end
    @(negedge clk); // T4
    ready = 0; ad_in = 16'($urandom);
    chk_data(w, m, be, wd, 0);
    chk("R9 done T4", done, 1); chk("R9 busy T4", busy, 0);
    if (!w) chk("R5 rdata", rdata, rd);
  endtask

  initial begin
    #2000000;
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk_idle();
    rst_n = 1;
    @(negedge clk);
    chk_idle(); // R1
    run(0, 1, 20'hA1234, 2'b11, 16'h0, 16'hBEEF, 0, 0);
    @(negedge clk); chk_idle(); chk("R9 done once", done, 0);
    run(1, 0, 20'h5F00F, 2'b01, 16'hC3A5, 16'h0, 3, 0);
    @(negedge clk); chk_idle();
    run(0, 0, 20'h0FFFF, 2'b10, 16'h0, 16'h1357, 2, 1); // R10
    @(negedge clk); chk_idle(); chk("R10 no extra cycle", ale, 0);
    run(1, 1, 20'hFFFFF, 2'b11, 16'h8001, 16'h0, 1, 1);
    run(0, 1, 20'h00001, 2'b01, 16'h0, 16'h7E7E, 0, 0); // R11 chained
    run(1, 0, 20'h80000, 2'b10, 16'hFFFF, 16'h0, 0, 0); // R11 chained
    @(negedge clk); chk_idle();
    for (int i = 0; i < 60; i++) begin
      run(1'($urandom), 1'($urandom), 20'($urandom), 2'($urandom_range(1, 3)),
          16'($urandom), 16'($urandom), $urandom_range(0, 4), 1'($urandom));
      if ($urandom_range(0, 1) == 1) begin
        @(negedge clk); chk_idle();
      end
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule